// File: doc/BRIEF.md
# Filtered Edge Input Capture Channel

This block combines a free-running up-counter time base with one input capture channel. The time base advances once every (prescale + 1) clock cycles. After it reaches the reload value it returns to zero and raises an update flag. A control input can force the count and the prescale phase to zero.

The capture channel takes an asynchronous pin and resynchronises it. A programmable digital filter then removes glitches from it. An edge detector picks rising or falling transitions, and the polarity may be switched while the counter runs. An edge divider keeps one of every 1, 2, 4 or 8 qualifying edges. On each kept edge the present count is copied into the capture register and the capture flag is raised.

Both flags are sticky and are cleared by a write-one-to-clear strobe. Each flag has its own interrupt enable. A typical use is to measure a pulse width. Capture the rising edge, switch the polarity to falling, capture again, and subtract the two values.

Top module: `edge_capture_unit`

## Requirements
- R1: While `runEn` is high and `zeroCnt` is low, `count` rises by one every (`psc` + 1) cycles. The value after `reload` is 0. While `runEn` is low, `count` holds its value.
- R2: `updFlag` is set in the cycle in which `count` wraps from `reload` to 0. It stays set until it is cleared.
- R3: `zeroCnt` clears both `count` and the prescale phase. After the clock edge that takes `zeroCnt`, `count` equals floor(j / (`psc` + 1)) mod (`reload` + 1) after j further edges.
- R4: A kept edge copies the current `count` into `capVal` and sets `capFlag`. The difference between two captures equals the elapsed counter ticks.
- R5: `polFalling` = 0 selects rising edges and 1 selects falling edges. Rewriting it while the filtered input is steady creates no capture.
- R6: `edgeDiv` codes 0, 1, 2 and 3 keep one edge in 1, 2, 4 and 8. The edge count restarts when `chanEn` is low or when `edgeDiv` changes.
- R7: With `filtCode` = 0 the pin is not filtered. With code c > 0 a new level is accepted only after 2c+2 consecutive equal samples, so code 3 needs 8. A shorter pulse produces no capture.
- R8: `clrCap` and `clrUpd` clear their flag at the next edge. A new event in that same cycle wins, and the flag stays set.
- R9: `capIrq` is high exactly when `capFlag` and `capIe` are both high. `updIrq` is high exactly when `updFlag` and `updIe` are both high.
- R10: While `chanEn` is low no capture occurs, and `capVal` and `capFlag` keep their values.
- R11: After reset, `count`, `capVal`, both flags and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer kernel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runEn | input | 1 | Counter run enable |
| zeroCnt | input | 1 | Force count and prescale phase to zero |
| psc | input | PSC_W | Clock divider value minus one |
| reload | input | CNT_W | Highest count value before the wrap |
| chanEn | input | 1 | Capture channel enable |
| pinIn | input | 1 | Asynchronous input pin |
| filtCode | input | FILT_W | Filter length code |
| polFalling | input | 1 | Edge polarity select |
| edgeDiv | input | 2 | Edge divider code |
| capIe | input | 1 | Capture interrupt enable |
| updIe | input | 1 | Update interrupt enable |
| clrCap | input | 1 | Write-one-to-clear for the capture flag |
| clrUpd | input | 1 | Write-one-to-clear for the update flag |
| count | output | CNT_W | Current counter value |
| capVal | output | CNT_W | Last captured count |
| capFlag | output | 1 | Capture event flag |
| updFlag | output | 1 | Update event flag |
| capIrq | output | 1 | Capture interrupt request |
| updIrq | output | 1 | Update interrupt request |

## Verification
The wrap property assumes that `reload` does not change while the counter runs. The stimulus therefore writes `reload` and `psc` only together with a `zeroCnt` pulse. The flag-fall property assumes that a flag is cleared only by its own strobe, so the bench never resets the block in the middle of a test. The bench drives the pin on falling clock edges, which keeps every pulse width an exact number of samples. Filter and divider boundaries can then be hit exactly one sample short and exactly on target.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  // Strobes sent from the channel control to the datapath
  typedef struct packed {
    logic capture;
  } ecuStrobe_t;
endpackage

// File: rtl/ecu_datapath.sv
module ecu_datapath
  import ecu_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              zeroCnt,
  input  logic [PSC_W-1:0]  psc,
  input  logic [CNT_W-1:0]  reload,
  input  logic              pinIn,
  input  logic [FILT_W-1:0] filtCode,
  input  ecuStrobe_t        stb,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  capVal,
  output logic              filtLvl,
  output logic              wrapEvt
);
  localparam int FCNT_W = FILT_W + 2;

  logic [PSC_W-1:0]  pscCnt;
  logic              pscHit;
  logic              syncA, syncB;
  logic [FCNT_W-1:0] fCnt, fNeedM1;

  // Time base
  assign pscHit  = (pscCnt == psc);
  assign wrapEvt = runEn && !zeroCnt && pscHit && (count == reload);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscCnt <= '0;
      count  <= '0;
    end else if (zeroCnt) begin
      pscCnt <= '0;
      count  <= '0;
    end else if (runEn) begin
      if (pscHit) begin
        pscCnt <= '0;
        count  <= (count == reload) ? '0 : count + CNT_W'(1);
      end else begin
        pscCnt <= pscCnt + PSC_W'(1);
      end
    end
  end

  // Two-flop synchronizer and consecutive-sample filter
  assign fNeedM1 = (filtCode == '0) ? '0 : FCNT_W'({filtCode, 1'b1});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      filtLvl <= 1'b0;
      fCnt    <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      if (syncB == filtLvl) begin
        fCnt <= '0;
      end else if (fCnt == fNeedM1) begin
        filtLvl <= syncB;
        fCnt    <= '0;
      end else begin
        fCnt <= fCnt + FCNT_W'(1);
      end
    end
  end

  // Capture register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            capVal <= '0;
    else if (stb.capture) capVal <= count;
  end
endmodule

// File: rtl/ecu_control.sv
module ecu_control
  import ecu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanEn,
  input  logic       polFalling,
  input  logic [1:0] edgeDiv,
  input  logic       filtLvl,
  input  logic       wrapEvt,
  input  logic       clrCap,
  input  logic       clrUpd,
  output ecuStrobe_t stb,
  output logic       capFlag,
  output logic       updFlag
);
  localparam int DIVC_W = 3;

  logic              prevLvl;
  logic [1:0]        prevDiv;
  logic [DIVC_W-1:0] divCnt, lastDiv;
  logic              riseEv, fallEv, qual, divHit, divReset;

  assign riseEv   = filtLvl && !prevLvl;
  assign fallEv   = !filtLvl && prevLvl;
  assign qual     = chanEn && (polFalling ? fallEv : riseEv);
  assign lastDiv  = DIVC_W'((4'd1 << edgeDiv) - 4'd1);
  assign divHit   = (divCnt == lastDiv);
  assign divReset = !chanEn || (edgeDiv != prevDiv);

  always_comb begin
    stb         = '0;
    stb.capture = qual && divHit && !divReset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLvl <= 1'b0;
      prevDiv <= '0;
      divCnt  <= '0;
      capFlag <= 1'b0;
      updFlag <= 1'b0;
    end else begin
      prevLvl <= filtLvl;
      prevDiv <= edgeDiv;
      if (divReset)  divCnt <= '0;
      else if (qual) divCnt <= divHit ? '0 : divCnt + DIVC_W'(1);
      capFlag <= stb.capture || (capFlag && !clrCap);
      updFlag <= wrapEvt || (updFlag && !clrUpd);
    end
  end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecu_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              zeroCnt,
  input  logic [PSC_W-1:0]  psc,
  input  logic [CNT_W-1:0]  reload,
  input  logic              chanEn,
  input  logic              pinIn,
  input  logic [FILT_W-1:0] filtCode,
  input  logic              polFalling,
  input  logic [1:0]        edgeDiv,
  input  logic              capIe,
  input  logic              updIe,
  input  logic              clrCap,
  input  logic              clrUpd,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  capVal,
  output logic              capFlag,
  output logic              updFlag,
  output logic              capIrq,
  output logic              updIrq
);
  ecuStrobe_t stb;
  logic       filtLvl, wrapEvt;

  ecu_datapath #(.CNT_W(CNT_W), .PSC_W(PSC_W), .FILT_W(FILT_W)) u_dp (
    .clk(clk), .rstN(rstN), .runEn(runEn), .zeroCnt(zeroCnt), .psc(psc),
    .reload(reload), .pinIn(pinIn), .filtCode(filtCode), .stb(stb),
    .count(count), .capVal(capVal), .filtLvl(filtLvl), .wrapEvt(wrapEvt)
  );

  ecu_control u_ctl (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .polFalling(polFalling),
    .edgeDiv(edgeDiv), .filtLvl(filtLvl), .wrapEvt(wrapEvt),
    .clrCap(clrCap), .clrUpd(clrUpd), .stb(stb),
    .capFlag(capFlag), .updFlag(updFlag)
  );

  assign capIrq = capFlag && capIe;
  assign updIrq = updFlag && updIe;
endmodule

// File: rtl/ecu_checker.sv
module ecu_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             runEn,
  input logic             chanEn,
  input logic             clrCap,
  input logic             capIe,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] capVal,
  input logic             capFlag,
  input logic             updFlag,
  input logic             capIrq
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |-> (count == $past(count) + CNT_W'(1) || count == '0)); // R1
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(runEn) && count != '0) |-> $stable(count)); // R1
  AST_UPD_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(updFlag) |-> ($past(count) == $past(reload))); // R2
  AST_CAPVAL_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (capVal != $past(capVal)) |-> capFlag); // R4
  AST_CAP_CLEAR_ONLY_BY_W1C: assert property (@(posedge clk) disable iff (!rstN)
    $fell(capFlag) |-> $past(clrCap)); // R8
  AST_CAPIRQ_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    capIrq |-> (capFlag && capIe)); // R9
  AST_NO_CAPTURE_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> $stable(capVal)); // R10
endmodule

bind edge_capture_unit ecu_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .chanEn(chanEn), .clrCap(clrCap),
  .capIe(capIe), .count(count), .reload(reload), .capVal(capVal),
  .capFlag(capFlag), .updFlag(updFlag), .capIrq(capIrq)
);

// File: tb/tb_edge_capture_unit.sv
`timescale 1ns/1ps
module tb_edge_capture_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 0, zeroCnt = 0, chanEn = 0, pinIn = 0, polFalling = 0;
  logic capIe = 0, updIe = 0, clrCap = 0, clrUpd = 0;
  logic [15:0] psc = 0, reload = 16'hFFFF;
  logic [3:0]  filtCode = 0;
  logic [1:0]  edgeDiv = 0;
  logic [15:0] count, capVal;
  logic capFlag, updFlag, capIrq, updIrq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  edge_capture_unit dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .zeroCnt(zeroCnt), .psc(psc),
    .reload(reload), .chanEn(chanEn), .pinIn(pinIn), .filtCode(filtCode),
    .polFalling(polFalling), .edgeDiv(edgeDiv), .capIe(capIe), .updIe(updIe),
    .clrCap(clrCap), .clrUpd(clrUpd), .count(count), .capVal(capVal),
    .capFlag(capFlag), .updFlag(updFlag), .capIrq(capIrq), .updIrq(updIrq)
  );

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic zeroAll();
    zeroCnt = 1; clrUpd = 1;
    step();
    zeroCnt = 0; clrUpd = 0;
  endtask

  task automatic clearCap();
    clrCap = 1; step(); clrCap = 0;
  endtask

  task automatic edgePulse();
    pinIn = 1; step(3); pinIn = 0; step(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    logic [15:0] b;
    step(3);
    // R11 reset state
    check("R11 count", count, 0);
    check("R11 capVal", capVal, 0);
    check("R11 flags", {capFlag, updFlag, capIrq, updIrq}, 0);
    rstN = 1;
    step();
    runEn = 1;

    // R1 R2 R3: counter sweep over prescale and reload
    for (int p = 0; p < 4; p++) begin
      for (int r = 3; r <= 5; r += 2) begin
        int k;
        psc = 16'(p); reload = 16'(r);
        k = (r + 1) * (p + 1);
        zeroAll();
        for (int j = 0; j <= 2 * k; j++) begin
          check("R1 R3 count", count, (j / (p + 1)) % (r + 1));
          check("R2 updFlag", updFlag, (j >= k) ? 1 : 0);
          step();
        end
        updIe = 0; step();
        check("R9 updIrq off", updIrq, 0);
        updIe = 1; step();
        check("R9 updIrq on", updIrq, 1);
        updIe = 0;
      end
    end

    // R8 update clear vs wrap in the same cycle
    psc = 1; reload = 3;
    zeroAll();
    step(7);
    clrUpd = 1; step(); clrUpd = 0;
    check("R8 upd event wins", updFlag, 1);
    clrUpd = 1; step(); clrUpd = 0;
    check("R8 upd cleared", updFlag, 0);

    // R1 hold while stopped
    runEn = 0; a = count; step(5);
    check("R1 hold", count, a);
    runEn = 1;

    // R4 R5 R7: pulse width sweep with polarity switch during the pulse
    psc = 0; reload = 16'hFFFF; zeroAll();
    chanEn = 1; edgeDiv = 0;
    for (int c = 0; c < 4; c++) begin
      for (int x = 0; x < 4; x++) begin
        int n;
        int w;
        n = (c == 0) ? 1 : 2 * c + 2;
        w = n + 8 + x;
        filtCode = 4'(c); polFalling = 0;
        clearCap();
        pinIn = 1; step(n + 6);
        check("R4 rise captured", capFlag, 1);
        a = capVal;
        polFalling = 1;
        clearCap();
        check("R5 no capture on polarity write", capFlag, 0);
        step(w - n - 7);
        pinIn = 0; step(n + 6);
        check("R5 fall captured", capFlag, 1);
        b = capVal;
        check("R4 width", 32'(b - a), w);
        polFalling = 0;
        clearCap();
      end
    end

    // R7 filter boundary: one sample short rejected, exact length accepted
    for (int c = 1; c < 4; c++) begin
      int n;
      n = 2 * c + 2;
      filtCode = 4'(c);
      clearCap();
      pinIn = 1; step(n - 1); pinIn = 0; step(n + 8);
      check("R7 short pulse rejected", capFlag, 0);
      pinIn = 1; step(n); pinIn = 0; step(n + 8);
      check("R7 full pulse accepted", capFlag, 1);
    end
    filtCode = 0;
    clearCap();

    // R6 edge divider sweep
    for (int d = 0; d < 4; d++) begin
      edgeDiv = 2'(d);
      chanEn = 0; step(); chanEn = 1; step();
      for (int i = 1; i <= 2 * (1 << d); i++) begin
        edgePulse();
        check("R6 divider", capFlag, (i % (1 << d) == 0) ? 1 : 0);
        clearCap();
      end
    end

    // R6 restart on code change
    edgeDiv = 2; chanEn = 0; step(); chanEn = 1; step();
    edgePulse(); edgePulse();
    check("R6 partial count", capFlag, 0);
    edgeDiv = 1; step(2);
    edgePulse();
    check("R6 restart first", capFlag, 0);
    edgePulse();
    check("R6 restart second", capFlag, 1);
    clearCap();

    // R6 restart on disable
    edgePulse();
    chanEn = 0; step(); chanEn = 1; step();
    edgePulse();
    check("R6 disable restart", capFlag, 0);
    edgePulse();
    check("R6 after restart", capFlag, 1);
    clearCap();

    // R10 disabled channel
    edgeDiv = 0;
    a = capVal;
    chanEn = 0; edgePulse();
    check("R10 no flag", capFlag, 0);
    check("R10 capVal kept", capVal, a);
    chanEn = 1; step();

    // R8 capture clear vs capture in the same cycle; R9 capIrq
    edgePulse();
    check("R8 flag set", capFlag, 1);
    a = capVal;
    pinIn = 1; step(3);
    clrCap = 1; step(); clrCap = 0;
    check("R8 cap event wins", capFlag, 1);
    check("R4 new value", (capVal != a) ? 1 : 0, 1);
    pinIn = 0; step(8);
    capIe = 0; step();
    check("R9 capIrq off", capIrq, 0);
    capIe = 1; step();
    check("R9 capIrq on", capIrq, 1);
    clearCap();
    check("R8 cap cleared", capFlag, 0);
    check("R9 capIrq after clear", capIrq, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule